// File: doc/BRIEF.md
# Two-Stage Baud Tick Generator

This block produces the timing enables for a serial transmitter and receiver. Two counters in cascade do the work. The first counter divides a selectable reference rate by a 16-bit divisor to make a bit-sample tick. The second counter divides the sample ticks by an 8-bit divisor plus one to make a baud tick. Both ticks are single-cycle enables in the system clock domain. No derived clock is produced.

The reference is chosen with a select input. With the select low the reference is every system-clock cycle. With the select high it is one cycle in eight, taken from a 3-bit prescaler. Each divisor has its own write strobe. An accepted write restarts the prescaler and both counters, so the new rate starts cleanly.

A first-stage divisor of zero stops both ticks. A second-stage write below four is dropped without any effect.

Top module: `baud_tick_gen`

## Requirements
- R1: After an accepted write with first-stage divisor N > 0, the first sample tick is seen N reference periods after the write edge, and the following sample ticks are N reference periods apart.
- R2: With ref_sel = 0 a reference period is one system-clock cycle. With ref_sel = 1 it is eight system-clock cycles.
- R3: A baud tick fires on every (B+1)-th sample tick, where B is the second-stage divisor. It is always high in the same cycle as a sample tick, so the first baud tick after a write comes N*(B+1) reference periods after the write.
- R4: A second-stage write with data below 4 is ignored. The divisor keeps its value and the counters are not restarted. Values from 4 to 255 are accepted.
- R5: A first-stage divisor of 0 keeps sample_tick and baud_tick low. A later nonzero write starts the ticks again per R1.
- R6: Any accepted write clears the prescaler and both counters, and forces both ticks low in the cycle that follows.
- R7: Each tick lasts one system-clock cycle. The only exception is N = 1 with ref_sel = 0, where sample_tick stays high continuously.
- R8: Reset sets the second-stage divisor to 15 and the first-stage divisor to DEF_SDIV (10). It also clears the counters and holds both ticks low. Ticks then follow R1 and R3, counted from the reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sel | input | 1 | Reference select: 0 selects every cycle, 1 selects the divide-by-8 prescaled enable |
| sdiv_we | input | 1 | Write strobe for the first-stage divisor |
| sdiv_wdata | input | 16 | First-stage divisor value (0 disables) |
| bdiv_we | input | 1 | Write strobe for the second-stage divisor |
| bdiv_wdata | input | 8 | Second-stage divisor value (values below 4 are ignored) |
| sample_tick | output | 1 | Bit-sample enable pulse |
| baud_tick | output | 1 | Baud enable pulse |

## Verification
The hardest case to reach from the ports is a rejected second-stage write that lands in the middle of a running period. It must change neither the divisor nor the phase of the counters. The bench starts a known configuration, issues a write of 3 a few cycles in, and checks two things. The first baud tick must still arrive on the schedule set by the original write, and the interval to the next baud tick must be unchanged. The zero-divisor stop and the 1-in-8 prescaled reference are each reached by their own directed write sequences.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int SDIV_W   = 16,
  parameter int BDIV_W   = 8,
  parameter int PRE_W    = 3,
  parameter int BDIV_MIN = 4,
  parameter int DEF_SDIV = 10,
  parameter int DEF_BDIV = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_sel,
  input  logic              sdiv_we,
  input  logic [SDIV_W-1:0] sdiv_wdata,
  input  logic              bdiv_we,
  input  logic [BDIV_W-1:0] bdiv_wdata,
  output logic              sample_tick,
  output logic              baud_tick
);

  logic [SDIV_W-1:0] sdiv_q, scnt;
  logic [BDIV_W-1:0] bdiv_q, bcnt;
  logic [PRE_W-1:0]  pcnt;

  wire bdiv_ok = bdiv_we && (bdiv_wdata >= BDIV_W'(BDIV_MIN));
  wire restart = sdiv_we || bdiv_ok;
  wire ref_en  = ref_sel ? (&pcnt) : 1'b1;
  wire s_end   = (sdiv_q != '0) && ref_en && (scnt == sdiv_q - SDIV_W'(1));
  wire b_end   = s_end && (bcnt == bdiv_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdiv_q <= SDIV_W'(DEF_SDIV);
      bdiv_q <= BDIV_W'(DEF_BDIV);
    end else begin
      if (sdiv_we) sdiv_q <= sdiv_wdata;
      if (bdiv_ok) bdiv_q <= bdiv_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt        <= '0;
      scnt        <= '0;
      bcnt        <= '0;
      sample_tick <= 1'b0;
      baud_tick   <= 1'b0;
    end else if (restart) begin
      pcnt        <= '0;
      scnt        <= '0;
      bcnt        <= '0;
      sample_tick <= 1'b0;
      baud_tick   <= 1'b0;
    end else begin
      pcnt        <= pcnt + PRE_W'(1);
      sample_tick <= s_end;
      baud_tick   <= b_end;
      if (s_end) begin
        scnt <= '0;
        bcnt <= b_end ? '0 : bcnt + BDIV_W'(1);
      end else if (ref_en && sdiv_q != '0) begin
        scnt <= scnt + SDIV_W'(1);
      end
    end
  end

  AST_BAUD_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> sample_tick); // R3

  AST_BDIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bdiv_q >= BDIV_W'(BDIV_MIN)); // R4

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bdiv_we && !sdiv_we && bdiv_wdata < BDIV_W'(BDIV_MIN)) |=> $stable(bdiv_q)); // R4

  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sdiv_q == '0) |-> (!sample_tick && !baud_tick)); // R5

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sdiv_we || bdiv_ok) |=> (!sample_tick && !baud_tick)); // R6

  AST_BAUD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick); // R7

  AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && sdiv_q > SDIV_W'(1)) |=> !sample_tick); // R7

endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  localparam int CLK_NS = 20;
  localparam int NV = 6;
  localparam int V_SEL [NV] = '{0, 0, 0, 1, 0, 1};
  localparam int V_N   [NV] = '{1, 3, 5, 2, 7, 1};
  localparam int V_B   [NV] = '{4, 4, 7, 4, 255, 5};
  localparam int V_ES  [NV] = '{1, 3, 5, 16, 7, 8};
  localparam int V_EB  [NV] = '{5, 15, 40, 80, 1792, 48};

  logic clk = 1'b0, rst_n = 1'b0, ref_sel = 1'b0;
  logic sdiv_we = 1'b0, bdiv_we = 1'b0;
  logic [15:0] sdiv_wdata = '0;
  logic [7:0]  bdiv_wdata = '0;
  logic sample_tick, baud_tick;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  baud_tick_gen uut (.clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .sdiv_we(sdiv_we),
    .sdiv_wdata(sdiv_wdata), .bdiv_we(bdiv_we), .bdiv_wdata(bdiv_wdata),
    .sample_tick(sample_tick), .baud_tick(baud_tick));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_both(input int sel, input int n, input int b);
    @(negedge clk);
    ref_sel = sel[0]; sdiv_we = 1'b1; sdiv_wdata = n[15:0];
    bdiv_we = 1'b1; bdiv_wdata = b[7:0];
    @(posedge clk); @(negedge clk);
    sdiv_we = 1'b0; bdiv_we = 1'b0;
  endtask

  task automatic observe(input int limit, input int rej_at, output int fs, output int fb,
                         output int sc, output int misalign);
    fs = 0; fb = 0; sc = 0; misalign = 0;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk); @(negedge clk);
      if (k == rej_at) begin bdiv_we = 1'b1; bdiv_wdata = 8'd3; end
      else bdiv_we = 1'b0;
      if (sample_tick) begin
        if (fs == 0) fs = k;
        if (fb == 0) sc++;
      end
      if (baud_tick && fb == 0) begin
        fb = k;
        if (!sample_tick) misalign = 1;
      end
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int fs, fb, sc, mis, fb2, cnt;
    repeat (3) @(negedge clk);
    chk(!sample_tick && !baud_tick, "R8 ticks low in reset", {sample_tick, baud_tick}, 0);
    rst_n = 1'b1;
    observe(165, 0, fs, fb, sc, mis);
    chk(fs == 10, "R8 default first-stage divisor", fs, 10);
    chk(fb == 160, "R8 default second-stage divisor 15", fb, 160);

    for (int i = 0; i < NV; i++) begin
      write_both(V_SEL[i], V_N[i], V_B[i]);
      observe(V_EB[i] + 2, 0, fs, fb, sc, mis);
      chk(fs == V_ES[i], V_SEL[i] ? "R2 prescaled first sample" : "R1 first sample", fs, V_ES[i]);
      chk(fb == V_EB[i], "R3 first baud tick", fb, V_EB[i]);
      chk(sc == V_B[i] + 1, "R7 R3 sample ticks per baud", sc, V_B[i] + 1);
      chk(mis == 0, "R3 baud aligned with sample", mis, 0);
    end

    write_both(0, 2, 6);
    observe(16, 5, fs, fb, sc, mis);
    chk(fb == 14, "R4 rejected write keeps phase", fb, 14);
    fb2 = 0;
    for (int k = 1; k <= 20; k++) begin
      @(posedge clk); @(negedge clk);
      if (baud_tick && fb2 == 0) fb2 = k;
    end
    chk(fb2 == 12, "R4 rejected write keeps divisor", fb2, 12);

    write_both(0, 4, 4);
    observe(6, 2, fs, fb, sc, mis);
    chk(fs == 4, "R6 restart then sample at N", fs, 4);
    chk(fb == 0, "R6 no early baud tick", fb, 0);

    write_both(0, 0, 4);
    cnt = 0;
    for (int k = 0; k < 100; k++) begin
      @(posedge clk); @(negedge clk);
      if (sample_tick || baud_tick) cnt++;
    end
    chk(cnt == 0, "R5 zero divisor stops ticks", cnt, 0);
    write_both(0, 3, 4);
    observe(17, 0, fs, fb, sc, mis);
    chk(fs == 3, "R5 resume sample", fs, 3);
    chk(fb == 15, "R5 resume baud", fb, 15);

    write_both(0, 3, 9);
    @(negedge clk); sdiv_we = 1'b1; sdiv_wdata = 16'd3; @(posedge clk); @(negedge clk); sdiv_we = 1'b0;
    chk(!sample_tick && !baud_tick, "R6 ticks low after write", {sample_tick, baud_tick}, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule